// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives the processor reset of a chip from a digital "supply is above its trip level" flag that an external comparator provides. While that flag is low, reset is held. After the flag has stayed high without interruption for a programmable hold period, reset is released. The hold period is counted in ticks of a prescaled system clock, so a real design can use a period of hundreds of milliseconds while a short simulation can use a few dozen cycles.

A watchdog can also be switched on. It watches the serial chip-select line of the host bus. Only a falling edge of that line counts as a kick. If the line stays at one level, high or low, for longer than the selected timeout, the watchdog forces a reset pulse. That pulse lasts exactly as long as a power-up hold. A two-bit select input turns the watchdog off or picks one of three timeouts. A parameter fixes the polarity of the reset output as active-low or active-high.

Both asynchronous inputs pass through two-flop synchronisers. The reset output comes from a register, so it never glitches.

Top module: `supply_reset_seq`

## Requirements
- R1: When the synchronous reset `rst` is released while `supply_ok_i` is low, the reset output is in its asserted level, and it stays there for as long as the supply flag stays low.
- R2: A fall of `supply_ok_i` while reset is released asserts the reset output exactly 4 clock cycles later (2 synchroniser stages, the state register and the output register).
- R3: After `supply_ok_i` rises and then stays high, the reset output is released exactly HOLD_TICKS*PRESCALE+4 cycles after the rise.
- R4: If `supply_ok_i` drops during the hold period, reset stays asserted and the hold restarts from zero. The release is timed from the last rise.
- R5: With ACTIVE_LOW=1, the asserted level of the output is 0. With ACTIVE_LOW=0, it is 1. The timing is the same in both variants.
- R6: With `wd_sel_i`=2'b00 the watchdog is off. The chip-select line can then stay at either level indefinitely without causing a reset.
- R7: With the watchdog on, each falling edge of `cs_n_i` clears the watchdog count. Falling edges spaced closer than the timeout keep reset released.
- R8: With the watchdog on and `cs_n_i` held constant (high or low), reset asserts exactly Tsel*PRESCALE cycles after it was released.
- R9: A watchdog reset pulse lasts exactly HOLD_TICKS*PRESCALE cycles. After it ends, the watchdog count starts again from zero, so an idle line trips again Tsel*PRESCALE cycles later.
- R10: The codes of `wd_sel_i` map to timeouts as follows: 2'b01 selects WD_T1 ticks, 2'b10 selects WD_T2 ticks and 2'b11 selects WD_T3 ticks, with WD_T1 < WD_T2 < WD_T3.
- R11: If the supply falls during a watchdog pulse, reset stays asserted, and the release then needs a full hold period after the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-above-trip flag from the comparator (asynchronous) |
| cs_n_i | input | 1 | Serial chip-select, active low (asynchronous) |
| wd_sel_i | input | 2 | Watchdog select: 00 off, 01/10/11 short/medium/long timeout |
| sys_rst_o | output | 1 | Processor reset, polarity set by ACTIVE_LOW |

## Verification
Two events can land on the same cycle: a fall of the supply flag and the watchdog's own reset pulse. Both compete for the state register. The bench provokes this by dropping the supply a few cycles into a watchdog pulse, then raising it again. The output must show no edge at all until a full hold period after the supply returns, and any extra edge is reported as unexpected. A second collision is a chip-select falling edge on the tick that would have tripped the watchdog. The bench judges that case through continuous kicking at a pitch below the timeout, with no reset edge allowed.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        SEQ_LOW  = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2,
        SEQ_WDOG = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic supply_ok;
        logic cs_n;
    } sync_in_t;

    localparam logic [1:0] WD_OFF = 2'b00;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int               W       = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end
endmodule

// File: rtl/srs_prescaler.sv
module srs_prescaler #(
    parameter int PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    if (PRESCALE <= 1) begin : g_pass
        assign tick_o = 1'b1;
    end else begin : g_div
        logic [PW-1:0] cnt_q;
        logic          wrap;
        assign wrap = (cnt_q == PW'(PRESCALE - 1));
        always_ff @(posedge clk) begin
            if (rst || clr_i) cnt_q <= '0;
            else if (wrap)    cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
        assign tick_o = wrap;
    end
endmodule

// File: rtl/srs_watchdog.sv
module srs_watchdog #(
    parameter int WD_T1 = 150,
    parameter int WD_T2 = 600,
    parameter int WD_T3 = 1400,
    parameter int WW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          arm_i,
    input  logic          cs_n_s_i,
    input  logic [1:0]    sel_i,
    output logic          cs_fall_o,
    output logic          trip_o,
    output logic [WW-1:0] cnt_o,
    output logic [WW-1:0] limit_o
);
    import srs_pkg::*;

    logic          cs_d_q;
    logic [WW-1:0] cnt_q;
    logic [WW-1:0] limit;
    logic          enabled;

    always_comb begin
        unique case (sel_i)
            2'b01:   limit = WW'(WD_T1);
            2'b10:   limit = WW'(WD_T2);
            2'b11:   limit = WW'(WD_T3);
            default: limit = '0;
        endcase
    end

    assign enabled   = (sel_i != WD_OFF);
    assign cs_fall_o = cs_d_q & ~cs_n_s_i;
    assign trip_o    = arm_i && enabled && tick_i && !cs_fall_o
                       && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) cs_d_q <= 1'b1;
        else     cs_d_q <= cs_n_s_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                               cnt_q <= '0;
        else if (!arm_i || !enabled || cs_fall_o) cnt_q <= '0;
        else if (trip_o)                       cnt_q <= '0;
        else if (tick_i)                       cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o   = cnt_q;
    assign limit_o = limit;
endmodule

// File: rtl/srs_sequencer.sv
module srs_sequencer #(
    parameter int HOLD_TICKS = 200,
    parameter int HW         = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     supply_ok_i,
    input  logic                     tick_i,
    input  logic                     wd_trip_i,
    output srs_pkg::seq_state_e      state_o,
    output logic [HW-1:0]            hold_cnt_o,
    output logic                     presc_clr_o,
    output logic                     rst_act_o
);
    import srs_pkg::*;

    seq_state_e    state_q, state_d;
    logic [HW-1:0] hold_q, hold_d;
    logic          act_q;
    logic          hold_last;

    assign hold_last = (hold_q == HW'(HOLD_TICKS - 1));

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        if (!supply_ok_i) begin
            state_d = SEQ_LOW;
            hold_d  = '0;
        end else begin
            unique case (state_q)
                SEQ_LOW: begin
                    state_d = SEQ_HOLD;
                    hold_d  = '0;
                end
                SEQ_HOLD, SEQ_WDOG: begin
                    if (tick_i) begin
                        if (hold_last) begin
                            state_d = SEQ_RUN;
                            hold_d  = '0;
                        end else begin
                            hold_d = hold_q + 1'b1;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (wd_trip_i) begin
                        state_d = SEQ_WDOG;
                        hold_d  = '0;
                    end
                end
                default: begin
                    state_d = SEQ_LOW;
                    hold_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_LOW;
            hold_q  <= '0;
            act_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            act_q   <= (state_q != SEQ_RUN);
        end
    end

    assign state_o     = state_q;
    assign hold_cnt_o  = hold_q;
    assign presc_clr_o = (state_q == SEQ_LOW) || wd_trip_i;
    assign rst_act_o   = act_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter bit ACTIVE_LOW = 1'b1,
    parameter int PRESCALE   = 1000,
    parameter int HOLD_TICKS = 200,
    parameter int WD_T1      = 150,
    parameter int WD_T2      = 600,
    parameter int WD_T3      = 1400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       cs_n_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o
);
    import srs_pkg::*;

    localparam int HW = cnt_width(HOLD_TICKS);
    localparam int WW = cnt_width(max3(WD_T1, WD_T2, WD_T3));

    sync_in_t      raw_in, syn_in;
    logic          sok_s;
    logic          tick;
    logic          presc_clr;
    logic          cs_fall;
    logic          wd_trip;
    logic [WW-1:0] wd_cnt;
    logic [WW-1:0] wd_limit;
    logic [HW-1:0] hold_cnt;
    logic          rst_act;
    seq_state_e    state;

    assign raw_in.supply_ok = supply_ok_i;
    assign raw_in.cs_n      = cs_n_i;

    srs_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    assign sok_s = syn_in.supply_ok;

    srs_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (presc_clr),
        .tick_o (tick)
    );

    srs_watchdog #(.WD_T1(WD_T1), .WD_T2(WD_T2), .WD_T3(WD_T3), .WW(WW)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .arm_i     (state == SEQ_RUN),
        .cs_n_s_i  (syn_in.cs_n),
        .sel_i     (wd_sel_i),
        .cs_fall_o (cs_fall),
        .trip_o    (wd_trip),
        .cnt_o     (wd_cnt),
        .limit_o   (wd_limit)
    );

    srs_sequencer #(.HOLD_TICKS(HOLD_TICKS), .HW(HW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (sok_s),
        .tick_i      (tick),
        .wd_trip_i   (wd_trip),
        .state_o     (state),
        .hold_cnt_o  (hold_cnt),
        .presc_clr_o (presc_clr),
        .rst_act_o   (rst_act)
    );

    if (ACTIVE_LOW) begin : g_act_low
        assign sys_rst_o = ~rst_act;
    end else begin : g_act_high
        assign sys_rst_o = rst_act;
    end
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
    parameter int HOLD_TICKS = 200,
    parameter int HW         = 8,
    parameter int WW         = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          sok_s,
    input logic          cs_fall,
    input logic          wd_trip,
    input logic [WW-1:0] wd_cnt,
    input logic [WW-1:0] wd_limit,
    input logic [HW-1:0] hold_cnt,
    input logic [1:0]    wd_sel,
    input logic          rst_act
);
    // R1 / R2: a low supply reaches the reset register two edges later
    a_r1_low_supply_holds: assert property (@(posedge clk) disable iff (rst)
        !sok_s |=> ##1 rst_act);

    // R3: a release is only possible after the supply was seen high
    a_r3_release_needs_supply: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_act) |-> $past(sok_s, 2));

    // R4: the hold counter never runs past its terminal value
    a_r4_hold_bounded: assert property (@(posedge clk) disable iff (rst)
        hold_cnt < HW'(HOLD_TICKS));

    // R7: a chip-select fall empties the watchdog count
    a_r7_kick_clears: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (wd_cnt == '0));

    // R8: a trip drives reset active
    a_r8_trip_asserts: assert property (@(posedge clk) disable iff (rst)
        wd_trip |=> ##1 rst_act);

    // R8 / R10: the count stays below the selected limit
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        (wd_cnt == '0) || (wd_cnt < wd_limit));

    // R6: the off code never trips
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (wd_sel == 2'b00) |-> !wd_trip);
endmodule

bind supply_reset_seq srs_chk #(
    .HOLD_TICKS (HOLD_TICKS),
    .HW         (HW),
    .WW         (WW)
) u_srs_chk (
    .clk      (clk),
    .rst      (rst),
    .sok_s    (sok_s),
    .cs_fall  (cs_fall),
    .wd_trip  (wd_trip),
    .wd_cnt   (wd_cnt),
    .wd_limit (wd_limit),
    .hold_cnt (hold_cnt),
    .wd_sel   (wd_sel_i),
    .rst_act  (rst_act)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int H  = 5;
    localparam int T1 = 3;
    localparam int T2 = 6;
    localparam int T3 = 9;
    localparam int HP = H * P;
    localparam int LAT = 4;

    typedef struct {
        logic  level;
        int    at;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sok = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       rst_n, rst_hi;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   mon_on = 1'b0;
    logic prev;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supply_reset_seq #(.ACTIVE_LOW(1'b1), .PRESCALE(P), .HOLD_TICKS(H),
                       .WD_T1(T1), .WD_T2(T2), .WD_T3(T3)) u_dut (
        .clk(clk), .rst(rst), .supply_ok_i(sok), .cs_n_i(cs_n),
        .wd_sel_i(sel), .sys_rst_o(rst_n));

    supply_reset_seq #(.ACTIVE_LOW(1'b0), .PRESCALE(P), .HOLD_TICKS(H),
                       .WD_T1(T1), .WD_T2(T2), .WD_T3(T3)) u_dut_hi (
        .clk(clk), .rst(rst), .supply_ok_i(sok), .cs_n_i(cs_n),
        .wd_sel_i(sel), .sys_rst_o(rst_hi));

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input logic lvl, input int offs, input string tag);
        exp_t e;
        e.level = lvl; e.at = cyc + offs; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic check_level(input logic lvl, input string req);
        check(rst_n === lvl, req, $sformatf("%b", rst_n), $sformatf("%b", lvl));
        check(rst_hi === ~lvl, "R5", $sformatf("%b", rst_hi), $sformatf("%b", ~lvl));
    endtask

    // scoreboard monitor: every output edge must match the queue head
    always @(negedge clk) begin
        if (mon_on && rst_n !== prev) begin
            if (expq.size() == 0) begin
                check(1'b0, "unexpected-edge", $sformatf("%b@%0d", rst_n, cyc), "no edge");
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rst_n === e.level && cyc == e.at, e.tag,
                      $sformatf("%b@%0d", rst_n, cyc), $sformatf("%b@%0d", e.level, e.at));
            end
            prev = rst_n;
        end
    end

    initial begin
        int c;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_level(1'b0, "R1");
        prev = rst_n;
        mon_on = 1'b1;
        repeat (20) @(negedge clk);
        check_level(1'b0, "R1");

        // R3: plain power-up release
        sok = 1'b1; push(1'b1, LAT + HP, "R3");
        wait_until(cyc + LAT + HP + 3);
        check_level(1'b1, "R3");

        // R6: watchdog off, line idle at both levels
        repeat (150) @(negedge clk);
        cs_n = 1'b0;
        repeat (150) @(negedge clk);
        check_level(1'b1, "R6");

        // R2: supply fall
        sok = 1'b0; push(1'b0, LAT, "R2");
        repeat (10) @(negedge clk);
        cs_n = 1'b1;

        // R4: interrupted hold restarts
        sok = 1'b1; repeat (10) @(negedge clk);
        sok = 1'b0; repeat (6) @(negedge clk);
        sok = 1'b1; push(1'b1, LAT + HP, "R4");
        wait_until(cyc + LAT + HP + 3);
        check_level(1'b1, "R4");
        sok = 1'b0; push(1'b0, LAT, "R2");
        repeat (10) @(negedge clk);

        // R7: steady kicking keeps reset released
        sel = 2'b01;
        sok = 1'b1; push(1'b1, LAT + HP, "R7 release");
        for (int k = 0; k < 30; k++) begin
            cs_n = 1'b0; repeat (4) @(negedge clk);
            cs_n = 1'b1; repeat (4) @(negedge clk);
        end
        check_level(1'b1, "R7");
        cs_n = 1'b0; @(negedge clk);
        sok = 1'b0; push(1'b0, LAT, "R2");
        repeat (10) @(negedge clk);

        // R8/R9/R10/R11 for each timeout code, idle high or low
        for (int s = 1; s <= 3; s++) begin
            int lp;
            lp = (s == 1) ? T1 * P : (s == 2) ? T2 * P : T3 * P;
            sel = 2'(s);
            cs_n = (s == 2) ? 1'b0 : 1'b1;
            repeat (5) @(negedge clk);
            sok = 1'b1; c = cyc;
            push(1'b1, LAT + HP, "R3");
            push(1'b0, LAT + HP + lp, "R8/R10 trip");
            push(1'b1, LAT + 2*HP + lp, "R9 pulse width");
            push(1'b0, LAT + 2*HP + 2*lp, "R9 restart");
            wait_until(c + LAT + 2*HP + 2*lp + 3);
            check_level(1'b0, "R9");
            sok = 1'b0; repeat (10) @(negedge clk);
            check_level(1'b0, "R11");
            sok = 1'b1; push(1'b1, LAT + HP, "R11");
            wait_until(cyc + LAT + HP + 3);
            sok = 1'b0; push(1'b0, LAT, "R2");
            repeat (10) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "pending", $sformatf("%0d left", expq.size()), "0 left");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule